// File: doc/BRIEF.md
# Skewed-Associative Write-Through Data Cache Controller

This block keeps the tags and valid bits of a primary data cache of one to four banks and sequences every access. Each bank finds its candidate slot through its own hashed index function of the memory block number, so two blocks that collide in one bank seldom collide in the others. The controller takes aligned 1, 2 or 4 byte read and write requests over a valid/ready handshake. It decides hit or miss, chooses a victim on a miss, and issues evict, fill and update commands to the next level over a second valid/ready port. Data movement is described only by bank, set, block number and byte-enable mask. The next level and the replacement choice for a full candidate set both sit outside the block.

Writes go through: every write ends with one update command, and on a write miss the block is allocated first. When a write covers a whole block, the fill is skipped because every byte will be overwritten anyway. A victim that holds valid contents is always evicted before the new block is loaded. An eviction never asks for a writeback, so the command has no flag for one.

The state machine has six states. IDLE accepts a request. LOOKUP compares tags and picks the target. EVICT, FILL and UPDATE each hold one command until the next level accepts it. RESP pulses the response for one cycle. The transitions are these:
- IDLE goes to LOOKUP when a request is accepted.
- LOOKUP goes to RESP on a read hit and to UPDATE on a write hit.
- On a miss, LOOKUP goes to EVICT if the victim is valid. If the victim is invalid, it goes to FILL, or to UPDATE for a full-block write.
- EVICT goes to FILL, or to UPDATE for a full-block write.
- FILL goes to UPDATE for a write and to RESP for a read.
- UPDATE goes to RESP.
- RESP returns to IDLE.

Top module: `skc_dcache_ctrl`

## Requirements
- R1: After reset every slot is invalid, req_ready is high, and cmd_valid and rsp_valid are low, so the first access to any address misses.
- R2: The set index in bank k is computed from the block number `bn` (address bits above the offset), where `n` is the set-index width. Let g1 = bn[n-1:0] and g2 = bn[2n-1:n]. First bit-reverse g1. Then rotate the result left by k mod n. Finally XOR it with g2 rotated left by one bit. Commands carry this index in cmd_set.
- R3: rsp_hit is 1 exactly when, in some bank, the slot picked by R2 is valid and its stored block number equals the full requested block number. A read hit issues no command.
- R4: On a miss the victim is the lowest-numbered bank whose candidate slot is invalid. Only if all candidates are valid is repl_bank used, and a repl_bank value not below the bank count selects bank 0.
- R5: If the victim slot is valid, an evict command (cmd_op 1) precedes any fill or update for the access. It carries the victim bank, the set and the block number it held, with cmd_be all zero. If the victim slot is invalid, no evict is issued.
- R6: A read miss, or a write miss that does not cover the whole block, issues one fill command (cmd_op 2) with the new block number and cmd_be all ones. The block becomes valid when the fill is accepted.
- R7: Every write, hit or miss, issues exactly one update command (cmd_op 3), after any fill. Its cmd_be is the access mask: 1, 2 or 4 ones for req_size 0, 1 or 2, shifted up by the byte offset. Reads never issue an update.
- R8: A write miss whose size equals the block size issues no fill. The block is installed when its update is accepted.
- R9: req_ready is high only in IDLE. A request offered at any other time is ignored and produces no command and no response.
- R10: Each accepted request yields exactly one response: rsp_valid is high for a single cycle, after the last command of the access is accepted.
- R11: A command held with cmd_ready low keeps cmd_op, cmd_bank, cmd_set, cmd_blk and cmd_be unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address, aligned to the access size |
| req_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2: 4 bytes |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Access hit in the cache |
| repl_bank | input | BANK_W | External replacement choice when all candidates are valid |
| cmd_valid | output | 1 | Command to the next level offered |
| cmd_ready | input | 1 | Next level accepts the command |
| cmd_op | output | 2 | 1 evict, 2 fill, 3 update |
| cmd_bank | output | BANK_W | Target bank |
| cmd_set | output | IDX_W | Target set within the bank |
| cmd_blk | output | BN_W | Block number (the old one for evict) |
| cmd_be | output | BLK_BYTES | Byte-enable mask within the block |

## Verification
The bound assertions watch the command and response protocol on every cycle: idle silence, command hold under back-pressure, the single-cycle response, byte-enable shapes per command kind, and ordering within an access. That ordering means an eviction precedes a fill to the same slot, no fill follows an update, and writes are updated while reads are not. Whether a hit is reported correctly, which bank is chosen as victim, the hashed set index and the stored block number can only be shown by the bench. The bench runs a long pseudo-random sweep over a three-bank, eight-set configuration against an arithmetic reference model, with periodic back-pressure and requests offered while busy.

// File: rtl/skc_pkg.sv
`timescale 1ns/1ps
package skc_pkg;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_EVICT  = 2'd1,
        CMD_FILL   = 2'd2,
        CMD_UPDATE = 2'd3
    } cmd_op_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOOKUP = 3'd1,
        ST_EVICT  = 3'd2,
        ST_FILL   = 3'd3,
        ST_UPDATE = 3'd4,
        ST_RESP   = 3'd5
    } ctl_state_e;

endpackage

// File: rtl/skc_index_hash.sv
`timescale 1ns/1ps
// Per-bank set index: rotl(bitrev(g1), ROT) ^ rotl1(g2). Wiring plus one XOR level.
module skc_index_hash #(
    parameter int BN_W  = 14,
    parameter int IDX_W = 4,
    parameter int ROT   = 0
) (
    input  logic [BN_W-1:0]  blk_num,
    output logic [IDX_W-1:0] set_idx
);
    logic [IDX_W-1:0] grp_lo;
    logic [IDX_W-1:0] grp_hi;
    logic [IDX_W-1:0] perm_lo;
    logic [IDX_W-1:0] perm_hi;
    logic [IDX_W-1:0] rot_lo;

    assign grp_lo = blk_num[IDX_W-1:0];
    assign grp_hi = blk_num[2*IDX_W-1:IDX_W];

    for (genvar i = 0; i < IDX_W; i++) begin : g_bits
        assign perm_lo[i]                   = grp_lo[IDX_W-1-i];
        assign perm_hi[(i+1) % IDX_W]       = grp_hi[i];
        assign rot_lo[(i+ROT) % IDX_W]      = perm_lo[i];
    end

    assign set_idx = rot_lo ^ perm_hi;
endmodule

// File: rtl/skc_tag_store.sv
`timescale 1ns/1ps
module skc_tag_store #(
    parameter int BANKS  = 2,
    parameter int SETS   = 16,
    parameter int BN_W   = 14,
    parameter int IDX_W  = 4,
    parameter int BANK_W = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [BANKS-1:0][IDX_W-1:0] lk_idx,
    output logic [BANKS-1:0]            lk_valid,
    output logic [BANKS-1:0][BN_W-1:0]  lk_tag,
    input  logic                        inv_en,
    input  logic [BANK_W-1:0]           inv_bank,
    input  logic [IDX_W-1:0]            inv_set,
    input  logic                        ins_en,
    input  logic [BANK_W-1:0]           ins_bank,
    input  logic [IDX_W-1:0]            ins_set,
    input  logic [BN_W-1:0]             ins_tag
);
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [SETS-1:0] vbits;
        logic [BN_W-1:0] tag_mem [SETS];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vbits <= '0;
            end else begin
                if (inv_en && inv_bank == BANK_W'(b)) vbits[inv_set] <= 1'b0;
                if (ins_en && ins_bank == BANK_W'(b)) vbits[ins_set] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (ins_en && ins_bank == BANK_W'(b)) tag_mem[ins_set] <= ins_tag;
        end

        assign lk_valid[b] = vbits[lk_idx[b]];
        assign lk_tag[b]   = tag_mem[lk_idx[b]];
    end
endmodule

// File: rtl/skc_victim_sel.sv
`timescale 1ns/1ps
module skc_victim_sel #(
    parameter int BANKS  = 2,
    parameter int BANK_W = 1
) (
    input  logic [BANKS-1:0]  cand_valid,
    input  logic [BANK_W-1:0] repl_bank,
    output logic [BANK_W-1:0] victim_bank
);
    always_comb begin
        if ({1'b0, repl_bank} < (BANK_W+1)'(BANKS)) victim_bank = repl_bank;
        else                                        victim_bank = '0;
        // Walk downward so the lowest invalid bank is the last to win.
        for (int k = BANKS - 1; k >= 0; k--) begin
            if (!cand_valid[k]) victim_bank = BANK_W'(k);
        end
    end
endmodule

// File: rtl/skc_dcache_ctrl.sv
`timescale 1ns/1ps
module skc_dcache_ctrl #(
    parameter int ADDR_W    = 16,
    parameter int BLK_BYTES = 4,
    parameter int SETS      = 16,
    parameter int BANKS     = 2,
    localparam int OFF_W  = $clog2(BLK_BYTES),
    localparam int IDX_W  = $clog2(SETS),
    localparam int BN_W   = ADDR_W - OFF_W,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_size,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    input  logic [BANK_W-1:0]    repl_bank,
    output logic                 cmd_valid,
    input  logic                 cmd_ready,
    output logic [1:0]           cmd_op,
    output logic [BANK_W-1:0]    cmd_bank,
    output logic [IDX_W-1:0]     cmd_set,
    output logic [BN_W-1:0]      cmd_blk,
    output logic [BLK_BYTES-1:0] cmd_be
);
    import skc_pkg::*;

    ctl_state_e state, nxt_state;

    // Latched request
    logic                 q_write;
    logic                 q_full;
    logic [BN_W-1:0]      q_bn;
    logic [BLK_BYTES-1:0] q_be;
    // Lookup outcome
    logic                 q_hit;
    logic                 q_fill;
    logic [BANK_W-1:0]    q_bank;
    logic [IDX_W-1:0]     q_set;
    logic [BN_W-1:0]      q_old;

    // Request decode
    logic [3:0]           size_mask;
    logic [BLK_BYTES-1:0] be_new;
    logic                 full_new;

    // Lookup
    logic [BANKS-1:0][IDX_W-1:0] bank_idx;
    logic [BANKS-1:0]            lk_valid;
    logic [BANKS-1:0][BN_W-1:0]  lk_tag;
    logic                        hit_any;
    logic [BANK_W-1:0]           hit_bank;
    logic [IDX_W-1:0]            hit_set;
    logic [BANK_W-1:0]           vic_bank;
    logic                        vic_valid;
    logic [IDX_W-1:0]            vic_set;
    logic [BN_W-1:0]             vic_tag;

    // Tag store control
    logic inv_en;
    logic ins_en;

    for (genvar b = 0; b < BANKS; b++) begin : g_hash
        skc_index_hash #(
            .BN_W  (BN_W),
            .IDX_W (IDX_W),
            .ROT   (b % IDX_W)
        ) u_hash (
            .blk_num (q_bn),
            .set_idx (bank_idx[b])
        );
    end

    skc_tag_store #(
        .BANKS  (BANKS),
        .SETS   (SETS),
        .BN_W   (BN_W),
        .IDX_W  (IDX_W),
        .BANK_W (BANK_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (bank_idx),
        .lk_valid (lk_valid),
        .lk_tag   (lk_tag),
        .inv_en   (inv_en),
        .inv_bank (q_bank),
        .inv_set  (q_set),
        .ins_en   (ins_en),
        .ins_bank (q_bank),
        .ins_set  (q_set),
        .ins_tag  (q_bn)
    );

    skc_victim_sel #(
        .BANKS  (BANKS),
        .BANK_W (BANK_W)
    ) u_victim (
        .cand_valid  (lk_valid),
        .repl_bank   (repl_bank),
        .victim_bank (vic_bank)
    );

    // Request byte mask and whole-block detection
    always_comb begin
        unique case (req_size)
            2'd0:    size_mask = 4'b0001;
            2'd1:    size_mask = 4'b0011;
            default: size_mask = 4'b1111;
        endcase
        be_new   = BLK_BYTES'(size_mask) << req_addr[OFF_W-1:0];
        full_new = req_write && (BLK_BYTES == 4) && (size_mask == 4'b1111);
    end

    // Tag compare across banks
    always_comb begin
        hit_any  = 1'b0;
        hit_bank = '0;
        for (int k = 0; k < BANKS; k++) begin
            if (!hit_any && lk_valid[k] && lk_tag[k] == q_bn) begin
                hit_any  = 1'b1;
                hit_bank = BANK_W'(k);
            end
        end
    end

    // Per-bank selection of set, valid and stored tag
    always_comb begin
        hit_set   = '0;
        vic_set   = '0;
        vic_valid = 1'b0;
        vic_tag   = '0;
        for (int k = 0; k < BANKS; k++) begin
            if (hit_bank == BANK_W'(k)) hit_set = bank_idx[k];
            if (vic_bank == BANK_W'(k)) begin
                vic_set   = bank_idx[k];
                vic_valid = lk_valid[k];
                vic_tag   = lk_tag[k];
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // Next state
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) nxt_state = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (hit_any)        nxt_state = q_write ? ST_UPDATE : ST_RESP;
                else if (vic_valid) nxt_state = ST_EVICT;
                else if (!q_full)   nxt_state = ST_FILL;
                else                nxt_state = ST_UPDATE;
            end
            ST_EVICT: begin
                if (cmd_ready) nxt_state = q_fill ? ST_FILL : ST_UPDATE;
            end
            ST_FILL: begin
                if (cmd_ready) nxt_state = q_write ? ST_UPDATE : ST_RESP;
            end
            ST_UPDATE: begin
                if (cmd_ready) nxt_state = ST_RESP;
            end
            ST_RESP: begin
                nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_write <= 1'b0;
            q_full  <= 1'b0;
            q_bn    <= '0;
            q_be    <= '0;
            q_hit   <= 1'b0;
            q_fill  <= 1'b0;
            q_bank  <= '0;
            q_set   <= '0;
            q_old   <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                q_write <= req_write;
                q_full  <= full_new;
                q_bn    <= req_addr[ADDR_W-1:OFF_W];
                q_be    <= be_new;
            end
            if (state == ST_LOOKUP) begin
                q_hit  <= hit_any;
                q_fill <= !hit_any && !q_full;
                q_bank <= hit_any ? hit_bank : vic_bank;
                q_set  <= hit_any ? hit_set  : vic_set;
                q_old  <= vic_tag;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        cmd_valid = 1'b0;
        cmd_op    = CMD_NONE;
        cmd_bank  = q_bank;
        cmd_set   = q_set;
        cmd_blk   = q_bn;
        cmd_be    = '0;
        inv_en    = 1'b0;
        ins_en    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_LOOKUP: begin
            end
            ST_EVICT: begin
                cmd_valid = 1'b1;
                cmd_op    = CMD_EVICT;
                cmd_blk   = q_old;
                inv_en    = cmd_ready;
            end
            ST_FILL: begin
                cmd_valid = 1'b1;
                cmd_op    = CMD_FILL;
                cmd_be    = '1;
                ins_en    = cmd_ready;
            end
            ST_UPDATE: begin
                cmd_valid = 1'b1;
                cmd_op    = CMD_UPDATE;
                cmd_be    = q_be;
                ins_en    = cmd_ready && !q_hit && !q_fill;
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                rsp_hit   = q_hit;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/skc_dcache_sva.sv
`timescale 1ns/1ps
module skc_dcache_sva #(
    parameter int BANK_W    = 1,
    parameter int IDX_W     = 4,
    parameter int BN_W      = 14,
    parameter int BLK_BYTES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 req_write,
    input logic                 rsp_valid,
    input logic                 cmd_valid,
    input logic                 cmd_ready,
    input logic [1:0]           cmd_op,
    input logic [BANK_W-1:0]    cmd_bank,
    input logic [IDX_W-1:0]     cmd_set,
    input logic [BN_W-1:0]      cmd_blk,
    input logic [BLK_BYTES-1:0] cmd_be
);
    logic              acc_write;
    logic              ev_seen;
    logic              upd_seen;
    logic [BANK_W-1:0] ev_bank;
    logic [IDX_W-1:0]  ev_set;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_write <= 1'b0;
            ev_seen   <= 1'b0;
            upd_seen  <= 1'b0;
            ev_bank   <= '0;
            ev_set    <= '0;
        end else if (req_valid && req_ready) begin
            acc_write <= req_write;
            ev_seen   <= 1'b0;
            upd_seen  <= 1'b0;
        end else if (cmd_valid && cmd_ready) begin
            if (cmd_op == 2'd1) begin
                ev_seen <= 1'b1;
                ev_bank <= cmd_bank;
                ev_set  <= cmd_set;
            end
            if (cmd_op == 2'd3) upd_seen <= 1'b1;
        end
    end

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!cmd_valid && !rsp_valid));

    p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_bank)
                                       && $stable(cmd_set) && $stable(cmd_blk) && $stable(cmd_be)));

    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    p_evict_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd1) |-> (cmd_be == '0));

    p_evict_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2 && ev_seen) |-> (cmd_bank == ev_bank && cmd_set == ev_set));

    p_fill_be_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2) |-> (cmd_be == '1));

    p_fill_before_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2) |-> !upd_seen);

    p_update_be_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd3) |->
            ($countones(cmd_be) == 1 || $countones(cmd_be) == 2 || $countones(cmd_be) == 4));

    p_write_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && acc_write) |-> upd_seen);

    p_read_no_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !acc_write) |-> !upd_seen);

    p_valid_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op != 2'd0));
endmodule

bind skc_dcache_ctrl skc_dcache_sva #(
    .BANK_W    (BANK_W),
    .IDX_W     (IDX_W),
    .BN_W      (BN_W),
    .BLK_BYTES (BLK_BYTES)
) sva_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_bank  (cmd_bank),
    .cmd_set   (cmd_set),
    .cmd_blk   (cmd_blk),
    .cmd_be    (cmd_be)
);

// File: tb/skc_dcache_ctrl_tb_top.sv
`timescale 1ns/1ps
module skc_dcache_ctrl_tb_top;
    localparam int ADDR_W = 12;
    localparam int BLKB   = 4;
    localparam int SETS   = 8;
    localparam int BANKS  = 3;
    localparam int NTXN   = 400;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid, req_ready, req_write;
    logic [11:0] req_addr;
    logic [1:0] req_size;
    logic       rsp_valid, rsp_hit;
    logic [1:0] repl_bank;
    logic       cmd_valid, cmd_ready;
    logic [1:0] cmd_op;
    logic [1:0] cmd_bank;
    logic [2:0] cmd_set;
    logic [9:0] cmd_blk;
    logic [3:0] cmd_be;

    always #4 clk = ~clk;

    skc_dcache_ctrl #(
        .ADDR_W (ADDR_W), .BLK_BYTES (BLKB), .SETS (SETS), .BANKS (BANKS)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_size (req_size),
        .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .repl_bank (repl_bank),
        .cmd_valid (cmd_valid), .cmd_ready (cmd_ready), .cmd_op (cmd_op),
        .cmd_bank (cmd_bank), .cmd_set (cmd_set), .cmd_blk (cmd_blk), .cmd_be (cmd_be)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // Monitor log of accepted commands and responses
    logic [1:0] lg_op   [2048];
    logic [1:0] lg_bank [2048];
    logic [2:0] lg_set  [2048];
    logic [9:0] lg_blk  [2048];
    logic [3:0] lg_be   [2048];
    int  n_cmd = 0;
    int  n_rsp = 0;
    logic last_hit = 1'b0;

    always @(negedge clk) begin
        if (rst_n && cmd_valid && cmd_ready && n_cmd < 2048) begin
            lg_op[n_cmd]   = cmd_op;
            lg_bank[n_cmd] = cmd_bank;
            lg_set[n_cmd]  = cmd_set;
            lg_blk[n_cmd]  = cmd_blk;
            lg_be[n_cmd]   = cmd_be;
            n_cmd++;
        end
        if (rst_n && rsp_valid) begin
            n_rsp++;
            last_hit = rsp_hit;
        end
    end

    // Reference model state
    bit         m_valid [BANKS][SETS];
    logic [9:0] m_tag   [BANKS][SETS];
    logic [1:0] e_op   [4];
    int         e_bank [4];
    logic [2:0] e_set  [4];
    logic [9:0] e_blk  [4];
    logic [3:0] e_be   [4];
    int         n_exp;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R2 index: rotl(bitrev(g1), k mod 3) ^ rotl1(g2)
    function automatic logic [2:0] mhash(input logic [9:0] bn, input int k);
        logic [2:0] g1, g2, p1, p2;
        logic [5:0] dbl;
        g1  = bn[2:0];
        g2  = bn[5:3];
        p1  = {g1[0], g1[1], g1[2]};
        p2  = {g2[1:0], g2[2]};
        dbl = {p1, p1} << (k % 3);
        return dbl[5:3] ^ p2;
    endfunction

    task automatic push(input logic [1:0] op, input int bank, input logic [2:0] set,
                        input logic [9:0] blk, input logic [3:0] be);
        e_op[n_exp]   = op;
        e_bank[n_exp] = bank;
        e_set[n_exp]  = set;
        e_blk[n_exp]  = blk;
        e_be[n_exp]   = be;
        n_exp++;
    endtask

    function automatic string op_req(input logic [1:0] op);
        if (op == 2'd1) return "R5";
        if (op == 2'd2) return "R6";
        return "R7";
    endfunction

    task automatic do_access(input bit wr, input logic [11:0] addr, input logic [1:0] sz,
                             input logic [1:0] repl, input bit noise, output bit was_hit);
        logic [9:0] bn;
        logic [3:0] be;
        bit   hit;
        int   hb, vb, bc, br, cyc, ncmp;
        bit   ready_bad;
        logic [2:0] vs;
        bn   = addr[11:2];
        be   = ((sz == 2'd0) ? 4'b0001 : (sz == 2'd1) ? 4'b0011 : 4'b1111) << addr[1:0];
        n_exp = 0;
        hit  = 0;
        hb   = 0;
        for (int k = 0; k < BANKS; k++) begin
            if (m_valid[k][mhash(bn, k)] && m_tag[k][mhash(bn, k)] == bn) begin
                hit = 1;
                hb  = k;
            end
        end
        if (hit) begin
            if (wr) push(2'd3, hb, mhash(bn, hb), bn, be);
        end else begin
            vb = -1;
            for (int k = 0; k < BANKS; k++)
                if (vb < 0 && !m_valid[k][mhash(bn, k)]) vb = k;
            if (vb < 0) vb = (int'(repl) < BANKS) ? int'(repl) : 0;
            vs = mhash(bn, vb);
            if (m_valid[vb][vs]) push(2'd1, vb, vs, m_tag[vb][vs], 4'h0);
            if (!(wr && sz == 2'd2)) push(2'd2, vb, vs, bn, 4'hF);
            if (wr) push(2'd3, vb, vs, bn, be);
            m_valid[vb][vs] = 1;
            m_tag[vb][vs]   = bn;
        end
        was_hit = hit;

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        bc = n_cmd;
        br = n_rsp;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_size  = sz;
        repl_bank = repl;
        @(negedge clk); #1;
        if (noise) begin
            req_addr  = addr ^ 12'h5A4;
            req_write = ~wr;
            req_size  = 2'd0;
        end else begin
            req_valid = 1'b0;
        end
        ready_bad = 0;
        cyc = 0;
        while (n_rsp == br && cyc < 300) begin
            if (req_ready) ready_bad = 1;
            @(negedge clk); #1;
            cyc++;
        end
        if (req_ready) ready_bad = 1;
        req_valid = 1'b0;
        @(negedge clk); #1;
        chk(cyc < 300, "R10 response timeout", cyc, 0);
        chk(n_rsp - br == 1, noise ? "R9 single response with busy request" : "R10 single pulse",
            n_rsp - br, 1);
        chk(!ready_bad, "R9 req_ready low while busy", ready_bad, 0);
        chk(last_hit == hit, "R3 hit flag", last_hit, hit);
        chk(n_cmd - bc == n_exp, (wr && sz == 2'd2 && !hit) ? "R8 command count" : "R7 command count",
            n_cmd - bc, n_exp);
        ncmp = (n_cmd - bc < n_exp) ? n_cmd - bc : n_exp;
        for (int i = 0; i < ncmp; i++) begin
            chk(lg_op[bc+i] == e_op[i], op_req(e_op[i]), lg_op[bc+i], e_op[i]);
            chk(lg_bank[bc+i] == 2'(e_bank[i]), "R4 bank", lg_bank[bc+i], e_bank[i]);
            chk(lg_set[bc+i] == e_set[i], "R2 set index", lg_set[bc+i], e_set[i]);
            chk(lg_blk[bc+i] == e_blk[i], op_req(e_op[i]), lg_blk[bc+i], e_blk[i]);
            chk(lg_be[bc+i] == e_be[i], op_req(e_op[i]), lg_be[bc+i], e_be[i]);
        end
    endtask

    // Next-level back-pressure: every fourth cycle not ready (R11 under load)
    initial begin
        int rc;
        rc = 0;
        cmd_ready = 1'b1;
        forever begin
            @(posedge clk); #1;
            rc++;
            cmd_ready = (rc % 4 != 3);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int unsigned r;
        bit h;
        logic [9:0] bn;
        logic [1:0] sz, off;
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_size  = '0;
        repl_bank = '0;
        for (int b = 0; b < BANKS; b++)
            for (int s = 0; s < SETS; s++) begin
                m_valid[b][s] = 0;
                m_tag[b][s]   = '0;
            end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
        chk(cmd_valid == 1'b0, "R1 cmd_valid after reset", cmd_valid, 0);
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);

        do_access(1'b0, 12'h000, 2'd2, 2'd0, 1'b0, h);
        chk(last_hit == 1'b0, "R1 first access misses", last_hit, 0);
        do_access(1'b0, 12'h002, 2'd1, 2'd0, 1'b0, h);
        chk(last_hit == 1'b1, "R3 second access hits", last_hit, 1);
        do_access(1'b1, 12'h404, 2'd2, 2'd1, 1'b0, h);   // full-block write miss, R8
        do_access(1'b1, 12'h809, 2'd0, 2'd2, 1'b1, h);   // partial write miss, busy request, R9

        seed = 32'h1234_5678;
        for (int i = 0; i < NTXN; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            r    = seed >> 6;
            bn   = 10'(((r % 48) * 37) % 1024);
            sz   = 2'((r >> 12) % 3);
            off  = (sz == 2'd0) ? 2'((r >> 16) & 3) : (sz == 2'd1) ? 2'(((r >> 16) & 1) << 1) : 2'd0;
            do_access(((r >> 20) & 3) < 2, {bn, off}, sz, 2'((r >> 23) & 3), (i % 5) == 0, h);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule